// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to 32 peripheral request lines and presents them to a processor as one interrupt output. It captures each rising edge on a request line into a status bit. A per-source enable mask selects which captured requests count as pending. A two-bit master register gates the processor line. Software reaches the block through a single-cycle register port. Writes take effect at the next clock edge. Reads are combinational from the current state.

The enable mask has three write paths. The full mask can be replaced in one write. Individual bits can be turned on or off through write-only set and clear aliases. Pending requests are retired by writing a mask to the acknowledge register. This lets an interrupt handler acknowledge everything it saw in one write and then service the sources in priority order. A read-only vector register reports the highest-numbered pending source, so the handler needs no software bit search.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, status, enable and master registers read 0, the vector register reads 0 (valid flag clear) and `irqOut` is low.
- R2: A rising edge (0 to 1 between consecutive clock edges) on `irqIn[i]` sets status bit i. A line held high does not set the bit again once it has been acknowledged.
- R3: A write to the acknowledge register (address 2) clears every status bit whose data bit is 1. Status bits written as 0 keep their value.
- R4: A rising edge on a source in the same cycle as an acknowledge or status write of that bit leaves the status bit set. A new edge after an acknowledge-all is latched again.
- R5: A write to the status register (address 0) replaces its value. Writing zero clears every bit.
- R6: Reading the pending register (address 1) returns status AND enable.
- R7: A write to the enable register (address 3) replaces the whole enable mask. A read of address 3 returns the mask.
- R8: A write to the set-enable alias (address 4) sets the enable bits written as 1. A write to the clear-enable alias (address 5) clears the enable bits written as 1. All other enable bits are unchanged, and both aliases read as 0.
- R9: The master register (address 6) holds hardware enable in bit 0 and master enable in bit 1. Bit 1 is accepted only when bit 0 was already set before the write. Writing both bits from the all-zero state sets bit 0 only.
- R10: `irqOut` is high exactly when both master bits are set and the pending value is non-zero.
- R11: The vector register (address 7) returns the index of the highest set pending bit in bits 4:0, with bit 31 as a valid flag. Higher index means higher priority.
- R12: Writes to the read-only pending and vector addresses change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | NUM_SRC | Peripheral request lines, rising-edge sensitive |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wrData | input | DATA_W | Register write data |
| rdData | output | DATA_W | Register read data, combinational from addr |
| irqOut | output | 1 | Interrupt request to the processor |

## Verification
Two functions can meet in one cycle: a new rising edge on a request line and an acknowledge write that clears the same status bit. The bench provokes this by raising the line and presenting the acknowledge write on the same falling clock edge. A neighbouring bit is acknowledged in the same write with no edge. The bit with the edge must read back set and the neighbour cleared. A second case acknowledges everything and then pulses a line, and that later request must be captured again.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;
  // Register word addresses on the 3-bit port.
  typedef enum logic [2:0] {
    REG_STATUS = 3'd0,
    REG_PEND   = 3'd1,
    REG_ACK    = 3'd2,
    REG_ENA    = 3'd3,
    REG_SETEN  = 3'd4,
    REG_CLREN  = 3'd5,
    REG_MASTER = 3'd6,
    REG_VECTOR = 3'd7
  } regSel_e;

  // Write strobes from the decoder to the datapath.
  typedef struct packed {
    logic wrStatus;
    logic ack;
    logic wrEnable;
    logic setEnable;
    logic clrEnable;
    logic wrMaster;
  } strobes_t;
endpackage

// File: rtl/vec_irq_decode.sv
module vec_irq_decode
  import vec_irq_pkg::*;
(
  input  logic       wrEn,
  input  logic [2:0] addr,
  output strobes_t   strb,
  output regSel_e    rdSel
);
  always_comb begin
    rdSel = regSel_e'(addr);
    strb  = '0;
    if (wrEn) begin
      unique case (rdSel)
        REG_STATUS: strb.wrStatus  = 1'b1;
        REG_ACK:    strb.ack       = 1'b1;
        REG_ENA:    strb.wrEnable  = 1'b1;
        REG_SETEN:  strb.setEnable = 1'b1;
        REG_CLREN:  strb.clrEnable = 1'b1;
        REG_MASTER: strb.wrMaster  = 1'b1;
        default:    strb = '0;  // pending and vector are read-only
      endcase
    end
  end
endmodule

// File: rtl/vec_irq_datapath.sv
module vec_irq_datapath
  import vec_irq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_SRC-1:0]        irqIn,
  input  strobes_t                  strb,
  input  regSel_e                   rdSel,
  input  logic [DATA_W-1:0]         wrData,
  output logic [DATA_W-1:0]         rdData,
  output logic                      irqOut,
  output logic [NUM_SRC-1:0]        statusQ,
  output logic [NUM_SRC-1:0]        enableQ,
  output logic [1:0]                masterQ,
  output logic [NUM_SRC-1:0]        pendQ,
  output logic [$clog2(NUM_SRC)-1:0] vecIdx,
  output logic                      vecValid
);
  localparam int IDX_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0] prevIn;
  logic [NUM_SRC-1:0] edgeSeen;
  logic [NUM_SRC-1:0] statusNext;
  logic [NUM_SRC-1:0] enableNext;
  logic [NUM_SRC-1:0] wrMask;
  logic [1:0]         masterNext;

  assign wrMask   = wrData[NUM_SRC-1:0];
  assign edgeSeen = irqIn & ~prevIn;

  // Per-source status update: a software write or acknowledge first, then a fresh edge on top.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic swBit;
    always_comb begin
      if (strb.wrStatus)              swBit = wrMask[i];
      else if (strb.ack && wrMask[i]) swBit = 1'b0;
      else                            swBit = statusQ[i];
    end
    assign statusNext[i] = swBit | edgeSeen[i];
  end

  always_comb begin
    enableNext = enableQ;
    if (strb.wrEnable)  enableNext = wrMask;
    if (strb.setEnable) enableNext = enableQ | wrMask;
    if (strb.clrEnable) enableNext = enableQ & ~wrMask;
  end

  always_comb begin
    masterNext = masterQ;
    if (strb.wrMaster) begin
      masterNext[0] = wrData[0];
      masterNext[1] = wrData[1] & masterQ[0];  // master only after hardware enable
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevIn  <= '0;
      statusQ <= '0;
      enableQ <= '0;
      masterQ <= '0;
    end else begin
      prevIn  <= irqIn;
      statusQ <= statusNext;
      enableQ <= enableNext;
      masterQ <= masterNext;
    end
  end

  assign pendQ = statusQ & enableQ;

  // Priority encoder: the last (highest) set bit wins.
  always_comb begin
    vecIdx   = '0;
    vecValid = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pendQ[i]) begin
        vecIdx   = IDX_W'(i);
        vecValid = 1'b1;
      end
    end
  end

  assign irqOut = masterQ[0] & masterQ[1] & (|pendQ);

  always_comb begin
    rdData = '0;
    unique case (rdSel)
      REG_STATUS: rdData[NUM_SRC-1:0] = statusQ;
      REG_PEND:   rdData[NUM_SRC-1:0] = pendQ;
      REG_ENA:    rdData[NUM_SRC-1:0] = enableQ;
      REG_MASTER: rdData[1:0]         = masterQ;
      REG_VECTOR: begin
        rdData[IDX_W-1:0]  = vecIdx;
        rdData[DATA_W-1]   = vecValid;
      end
      default:    rdData = '0;  // write-only aliases
    endcase
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vec_irq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic               wrEn,
  input  logic [2:0]         addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut
);
  localparam int IDX_W = $clog2(NUM_SRC);

  strobes_t           strb;
  regSel_e            rdSel;
  logic [NUM_SRC-1:0] statusQ;
  logic [NUM_SRC-1:0] enableQ;
  logic [1:0]         masterQ;
  logic [NUM_SRC-1:0] pendQ;
  logic [IDX_W-1:0]   vecIdx;
  logic               vecValid;

  vec_irq_decode decode_i (
    .wrEn  (wrEn),
    .addr  (addr),
    .strb  (strb),
    .rdSel (rdSel)
  );

  vec_irq_datapath #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) datapath_i (
    .clk      (clk),
    .rstN     (rstN),
    .irqIn    (irqIn),
    .strb     (strb),
    .rdSel    (rdSel),
    .wrData   (wrData),
    .rdData   (rdData),
    .irqOut   (irqOut),
    .statusQ  (statusQ),
    .enableQ  (enableQ),
    .masterQ  (masterQ),
    .pendQ    (pendQ),
    .vecIdx   (vecIdx),
    .vecValid (vecValid)
  );
endmodule

// File: rtl/vec_irq_chk.sv
module vec_irq_chk #(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [NUM_SRC-1:0]         irqIn,
  input logic                       wrEn,
  input logic [2:0]                 addr,
  input logic [DATA_W-1:0]          wrData,
  input logic                       irqOut,
  input logic [NUM_SRC-1:0]         statusQ,
  input logic [NUM_SRC-1:0]         enableQ,
  input logic [1:0]                 masterQ,
  input logic [NUM_SRC-1:0]         pendQ,
  input logic [$clog2(NUM_SRC)-1:0] vecIdx,
  input logic                       vecValid
);
  logic [NUM_SRC-1:0] lastIn;
  logic [NUM_SRC-1:0] edgeD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastIn <= '0;
      edgeD  <= '0;
    end else begin
      lastIn <= irqIn;
      edgeD  <= irqIn & ~lastIn;
    end
  end

  // R2 / R4: every edge observed last cycle is visible in status now.
  a_r2_edge_latched: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ & edgeD) == edgeD);

  // R3: acknowledged bits are clear next cycle unless a new edge arrived.
  a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'd2) |=> ((statusQ & $past(wrData[NUM_SRC-1:0]) & ~edgeD) == '0));

  // R7: a full enable write lands as written.
  a_r7_enable_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'd3) |=> (enableQ == $past(wrData[NUM_SRC-1:0])));

  // R9: master enable rises only while hardware enable was already set.
  a_r9_master_order: assert property (@(posedge clk) disable iff (!rstN)
    $rose(masterQ[1]) |-> $past(masterQ[0]));

  // R10: the processor line needs both master bits and something pending.
  a_r10_irq_gate: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (masterQ == 2'b11 && pendQ != '0));

  // R11: a valid vector points at a pending bit with nothing pending above it.
  a_r11_vector_top: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> (pendQ[vecIdx] && ((pendQ >> vecIdx) >> 1) == '0));
endmodule

bind vec_irq_ctrl vec_irq_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .irqIn    (irqIn),
  .wrEn     (wrEn),
  .addr     (addr),
  .wrData   (wrData),
  .irqOut   (irqOut),
  .statusQ  (statusQ),
  .enableQ  (enableQ),
  .masterQ  (masterQ),
  .pendQ    (pendQ),
  .vecIdx   (vecIdx),
  .vecValid (vecValid)
);

// File: tb/vec_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module vec_irq_ctrl_tb_top;
  localparam int NUM_SRC = 32;
  localparam int DATA_W  = 32;

  localparam logic [2:0] A_STATUS = 3'd0;
  localparam logic [2:0] A_PEND   = 3'd1;
  localparam logic [2:0] A_ACK    = 3'd2;
  localparam logic [2:0] A_ENA    = 3'd3;
  localparam logic [2:0] A_SETEN  = 3'd4;
  localparam logic [2:0] A_CLREN  = 3'd5;
  localparam logic [2:0] A_MASTER = 3'd6;
  localparam logic [2:0] A_VECTOR = 3'd7;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [NUM_SRC-1:0] irqIn = '0;
  logic               wrEn = 1'b0;
  logic [2:0]         addr = '0;
  logic [DATA_W-1:0]  wrData = '0;
  logic [DATA_W-1:0]  rdData;
  logic               irqOut;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  vec_irq_ctrl #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic pulseIrq(input logic [31:0] m);
    @(negedge clk);
    irqIn = irqIn | m;
    @(negedge clk);
    irqIn = irqIn & ~m;
  endtask

  task automatic testReset();
    logic [31:0] v;
    rdReg(A_STATUS, v); check("R1 status", v, 32'h0);
    rdReg(A_ENA, v);    check("R1 enable", v, 32'h0);
    rdReg(A_MASTER, v); check("R1 master", v, 32'h0);
    rdReg(A_VECTOR, v); check("R1 vector", v, 32'h0);
    check("R1 irqOut", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic testEdge();
    logic [31:0] v;
    pulseIrq(32'h20);
    rdReg(A_STATUS, v); check("R2 edge sets bit", v, 32'h20);
    @(negedge clk); irqIn[7] = 1'b1;
    @(negedge clk);
    wrReg(A_ACK, 32'h80);
    repeat (3) @(negedge clk);
    rdReg(A_STATUS, v); check("R2 held level no re-set", v, 32'h20);
    @(negedge clk); irqIn[7] = 1'b0;
  endtask

  task automatic testAck();
    logic [31:0] v;
    pulseIrq(32'h200);
    wrReg(A_ACK, 32'h20);
    rdReg(A_STATUS, v); check("R3 ack clears only ones", v, 32'h200);
  endtask

  task automatic testStatusWrite();
    logic [31:0] v;
    wrReg(A_STATUS, 32'h0);
    rdReg(A_STATUS, v); check("R5 status write zero", v, 32'h0);
    wrReg(A_STATUS, 32'h0000_000F);
    rdReg(A_STATUS, v); check("R5 status write value", v, 32'hF);
  endtask

  task automatic testEnable();
    logic [31:0] v;
    wrReg(A_ENA, 32'hF0F0_0000);
    rdReg(A_ENA, v); check("R7 enable replace", v, 32'hF0F0_0000);
    wrReg(A_SETEN, 32'h1);
    rdReg(A_ENA, v); check("R8 set alias", v, 32'hF0F0_0001);
    wrReg(A_CLREN, 32'h1000_0000);
    rdReg(A_ENA, v); check("R8 clear alias", v, 32'hE0F0_0001);
    rdReg(A_SETEN, v); check("R8 alias reads zero", v, 32'h0);
  endtask

  task automatic testPendVec();
    logic [31:0] v;
    wrReg(A_STATUS, 32'h11);
    wrReg(A_ENA, 32'h10);
    rdReg(A_PEND, v);   check("R6 pending", v, 32'h10);
    rdReg(A_VECTOR, v); check("R11 vector 4", v, 32'h8000_0004);
    wrReg(A_ENA, 32'hFFFF_FFFF);
    wrReg(A_STATUS, 32'h8000_0001);
    rdReg(A_VECTOR, v); check("R11 vector 31", v, 32'h8000_001F);
    wrReg(A_STATUS, 32'h0000_000A);
    rdReg(A_VECTOR, v); check("R11 vector 3", v, 32'h8000_0003);
  endtask

  task automatic testMaster();
    logic [31:0] v;
    wrReg(A_MASTER, 32'h3);
    rdReg(A_MASTER, v); check("R9 both from zero", v, 32'h1);
    check("R10 irq off with hw only", {31'b0, irqOut}, 32'h0);
    wrReg(A_MASTER, 32'h3);
    rdReg(A_MASTER, v); check("R9 master after hw", v, 32'h3);
    check("R10 irq on", {31'b0, irqOut}, 32'h1);
    wrReg(A_ENA, 32'h0);
    #1 check("R10 irq off when masked", {31'b0, irqOut}, 32'h0);
    wrReg(A_MASTER, 32'h0);
    wrReg(A_MASTER, 32'h2);
    rdReg(A_MASTER, v); check("R9 master alone refused", v, 32'h0);
  endtask

  task automatic testRace();
    logic [31:0] v;
    wrReg(A_STATUS, 32'h3000);
    @(negedge clk);
    wrEn = 1'b1; addr = A_ACK; wrData = 32'h3000; irqIn[12] = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; irqIn[12] = 1'b0;
    rdReg(A_STATUS, v); check("R4 edge beats ack", v, 32'h1000);
    wrReg(A_ACK, 32'hFFFF_FFFF);
    rdReg(A_STATUS, v); check("R3 ack all", v, 32'h0);
    pulseIrq(32'h4000_0000);
    rdReg(A_STATUS, v); check("R4 new edge after ack all", v, 32'h4000_0000);
  endtask

  task automatic testReadOnly();
    logic [31:0] v;
    wrReg(A_ENA, 32'h0000_00FF);
    wrReg(A_PEND, 32'hFFFF_FFFF);
    wrReg(A_VECTOR, 32'hFFFF_FFFF);
    rdReg(A_STATUS, v); check("R12 status untouched", v, 32'h4000_0000);
    rdReg(A_ENA, v);    check("R12 enable untouched", v, 32'h0000_00FF);
    rdReg(A_MASTER, v); check("R12 master untouched", v, 32'h0);
  endtask

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testEdge();
    testAck();
    testStatusWrite();
    testEnable();
    testPendVec();
    testMaster();
    testRace();
    testReadOnly();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule